// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches software through a compare value. Each refresh moves the deadline to the current system count plus a programmable 48-bit timeout. Software refreshes by writing to a refresh register or by reprogramming the timeout or control fields. If the count reaches the deadline once, the block raises an interrupt and moves the deadline forward by the same timeout. If the count reaches the deadline a second time with no refresh in between, the block asserts a reset request.

The registers sit in two 4 KiB frames, selected by `bus_frame` (0 = refresh frame, 1 = control frame). Every access is a 32-bit word, and the byte offset is on `bus_addr`. A write takes effect at the clock edge where `bus_valid` is high. Read data appears on `bus_rdata` one cycle after the request. The system counter comes in on `sys_count`. This block does not produce the counter.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, `wdog_irq` and `wdog_rst_req` are low. The control word, the timeout and the compare value all read zero.
- R2: Offset 0xFCC in either frame reads the constant 0x0001043B.
- R3: A read of refresh-frame offset 0x000 returns zero and changes no state.
- R4: Control offset 0x000 is the control word: bit 0 = enable, bit 1 = first-stage flag, bit 2 = second-stage flag. A write to it does three things: it loads enable from data bit 0, clears both flags and performs a refresh.
- R5: A write to refresh-frame offset 0x000 clears both flags and performs a refresh. So does a write to control offset 0x008 (timeout bits 31:0) or 0x00C (timeout bits 47:32, taken from data bits 15:0, with the upper data bits dropped).
- R6: A refresh while enabled sets compare to `sys_count` plus the new timeout. Compare reads back at control offsets 0x010 (low word) and 0x014 (high word). While disabled, a refresh leaves compare unchanged and no expiry occurs.
- R7: Expiry is an unsigned test `sys_count >= compare`, made once per clock. An expiry while the first-stage flag is clear has three effects: it sets that flag, reloads compare with `sys_count` plus the timeout, and drives `wdog_irq` high in the following cycle.
- R8: An expiry while the first-stage flag is set sets the second-stage flag, which drives `wdog_rst_req` high. `wdog_rst_req` is never high while `wdog_irq` is low.
- R9: Writes to control offsets 0x010 and 0x014 overwrite the matching half of compare and leave both flags unchanged. In that cycle the write takes priority over an expiry.
- R10: A write whose byte enable `bus_be` is not 4'hF has no effect, and neither does a write to an unmapped offset. A read of either kind returns zero.
- R11: `bus_rdata` holds the read value in the cycle after a read request and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_count | input | CNT_W | Free-running system count |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = refresh frame, 1 = control frame |
| bus_addr | input | 12 | Byte offset inside the frame |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| wdog_irq | output | 1 | First-stage interrupt; follows the first-stage flag |
| wdog_rst_req | output | 1 | Second-stage reset request |

## Verification
The bench uses the default parameters: a 64-bit count and a 48-bit timeout. The count is a port, so the bench can jump it close to the top of the 64-bit range and check that compare wraps when the reload overflows. It keeps timeouts small so that both expiry stages, and the races between writes and expiry, happen many times within a short run.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned OFS_W  = 48,
  parameter logic [31:0] ID_VAL = 32'h0001_043B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sys_count,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic             bus_frame,
  input  logic [11:0]      bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             wdog_irq,
  output logic             wdog_rst_req
);
  localparam int unsigned HI_W = OFS_W - 32;

  logic             en, ws0, ws1;
  logic [OFS_W-1:0] off, off_nx;
  logic [CNT_W-1:0] cmp, reload;
  logic [63:0]      cmp64;
  logic [31:0]      rd_val;

  wire full   = bus_valid && (bus_be == 4'hF);
  wire wr     = full && bus_write;
  wire rd     = full && !bus_write;
  wire wr_rr  = wr && !bus_frame && bus_addr == 12'h000;
  wire wr_cs  = wr &&  bus_frame && bus_addr == 12'h000;
  wire wr_ol  = wr &&  bus_frame && bus_addr == 12'h008;
  wire wr_oh  = wr &&  bus_frame && bus_addr == 12'h00C;
  wire wr_cl  = wr &&  bus_frame && bus_addr == 12'h010;
  wire wr_ch  = wr &&  bus_frame && bus_addr == 12'h014;
  wire refresh  = wr_rr || wr_cs || wr_ol || wr_oh;
  wire state_wr = refresh || wr_cl || wr_ch;
  wire en_nx    = wr_cs ? bus_wdata[0] : en;
  wire hit      = en && (sys_count >= cmp);

  always_comb begin
    off_nx = off;
    if (wr_ol) off_nx[31:0] = bus_wdata;
    if (wr_oh) off_nx[OFS_W-1:32] = bus_wdata[HI_W-1:0];
  end

  assign reload = sys_count + CNT_W'(off_nx);
  assign cmp64  = 64'(cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ws0 <= 1'b0; ws1 <= 1'b0;
      off <= '0;  cmp <= '0;
    end else if (refresh) begin
      en  <= en_nx;
      ws0 <= 1'b0;
      ws1 <= 1'b0;
      off <= off_nx;
      if (en_nx) cmp <= reload;
    end else if (wr_cl || wr_ch) begin
      if (wr_cl) cmp[31:0] <= bus_wdata;
      if (wr_ch) cmp[CNT_W-1:32] <= bus_wdata[CNT_W-33:0];
    end else if (hit) begin
      if (!ws0) begin
        ws0 <= 1'b1;
        cmp <= reload;
      end else begin
        ws1 <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == 12'hFCC) rd_val = ID_VAL;
    else if (bus_frame) begin
      case (bus_addr)
        12'h000: rd_val = {29'd0, ws1, ws0, en};
        12'h008: rd_val = off[31:0];
        12'h00C: rd_val = 32'(off[OFS_W-1:32]);
        12'h010: rd_val = cmp64[31:0];
        12'h014: rd_val = cmp64[63:32];
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd ? rd_val : '0;
  end

  assign wdog_irq     = ws0;
  assign wdog_rst_req = ws1;

  a_r5_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !wdog_irq && !wdog_rst_req);

  a_r7_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ws0 && !state_wr) |=> wdog_irq && cmp == $past(sys_count + CNT_W'(off)));

  a_r8_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ws0 && !state_wr) |=> wdog_rst_req);

  a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> wdog_irq);

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !state_wr) |=> $stable(wdog_irq) && $stable(wdog_rst_req));

  a_r9_cmp_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_cl || wr_ch) && !refresh) |=> $stable(wdog_irq) && $stable(wdog_rst_req));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> bus_rdata == 32'd0);
endmodule

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_EXP = 32'h0001_043B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic bus_valid = 0, bus_write = 0, bus_frame = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic wdog_irq, wdog_rst_req;

  int vecs = 0, errs = 0;
  logic [63:0] cnt = 64'd100;
  logic m_en = 0, m_ws0 = 0, m_ws1 = 0;
  logic [47:0] m_off = '0;
  logic [63:0] m_cmp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_stage dut_i (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdog_irq(wdog_irq), .wdog_rst_req(wdog_rst_req));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic f, logic [11:0] a);
    if (a == 12'hFCC) return ID_EXP;
    if (!f) return 32'd0;
    case (a)
      12'h000: return {29'd0, m_ws1, m_ws0, m_en};
      12'h008: return m_off[31:0];
      12'h00C: return {16'd0, m_off[47:32]};
      12'h010: return m_cmp[31:0];
      12'h014: return m_cmp[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic op(logic v, logic w, logic f, logic [11:0] a, logic [3:0] be,
                    logic [31:0] d, logic [63:0] stp, string tag);
    logic full, wr, rd, rr, cs, ol, oh, cl, ch, refr, en_n;
    logic [47:0] off_n;
    logic [31:0] exp_rd;
    bus_valid = v; bus_write = w; bus_frame = f; bus_addr = a; bus_be = be;
    bus_wdata = d; sys_count = cnt;
    full = v && be == 4'hF;
    wr = full && w; rd = full && !w;
    rr = wr && !f && a == 12'h000;
    cs = wr && f && a == 12'h000;
    ol = wr && f && a == 12'h008;
    oh = wr && f && a == 12'h00C;
    cl = wr && f && a == 12'h010;
    ch = wr && f && a == 12'h014;
    exp_rd = rd ? model_read(f, a) : 32'd0;
    refr = rr || cs || ol || oh;
    en_n = cs ? d[0] : m_en;
    off_n = m_off;
    if (ol) off_n[31:0] = d;
    if (oh) off_n[47:32] = d[15:0];
    if (refr) begin
      m_en = en_n; m_ws0 = 0; m_ws1 = 0; m_off = off_n;
      if (en_n) m_cmp = cnt + {16'd0, off_n};
    end else if (cl || ch) begin
      if (cl) m_cmp[31:0] = d;
      if (ch) m_cmp[63:32] = d;
    end else if (m_en && cnt >= m_cmp) begin
      if (!m_ws0) begin m_ws0 = 1; m_cmp = cnt + {16'd0, m_off}; end
      else m_ws1 = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R7 irq"}, {63'd0, wdog_irq}, {63'd0, m_ws0});
    chk({tag, " R8 rst_req"}, {63'd0, wdog_rst_req}, {63'd0, m_ws1});
    chk({tag, " R11 rdata"}, {32'd0, bus_rdata}, {32'd0, exp_rd});
    bus_valid = 0;
    cnt = cnt + stp;
  endtask

  task automatic rd_lit(logic f, logic [11:0] a, logic [31:0] lit, string tag);
    op(1, 0, f, a, 4'hF, 0, 1, tag);
    chk({tag, " literal"}, {32'd0, bus_rdata}, {32'd0, lit});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {63'd0, wdog_irq}, 0);
    chk("R1 rst_req", {63'd0, wdog_rst_req}, 0);
    rd_lit(1, 12'h000, 0, "R1 ctrl");
    rd_lit(1, 12'h010, 0, "R1 cmp lo");
    rd_lit(1, 12'h00C, 0, "R1 ofs hi");
    // R2 identification in both frames
    rd_lit(0, 12'hFCC, ID_EXP, "R2 id refresh frame");
    rd_lit(1, 12'hFCC, ID_EXP, "R2 id control frame");
    // R3 refresh register read
    rd_lit(0, 12'h000, 0, "R3 refresh read");
    // R10 partial write ignored, unmapped and partial read zero
    op(1, 1, 1, 12'h008, 4'h3, 32'h55, 1, "R10 partial write");
    rd_lit(1, 12'h008, 0, "R10 ofs lo unchanged");
    op(1, 1, 1, 12'h020, 4'hF, 32'hFF, 1, "R10 unmapped write");
    rd_lit(1, 12'h020, 0, "R10 unmapped read");
    op(1, 0, 1, 12'hFCC, 4'h1, 0, 1, "R10 partial read");
    chk("R10 partial read literal", {32'd0, bus_rdata}, 0);
    // R5 high timeout word is masked to 16 bits
    op(1, 1, 1, 12'h00C, 4'hF, 32'h000A_BCD1, 1, "R5 ofs hi");
    rd_lit(1, 12'h00C, 32'h0000_BCD1, "R5 ofs hi mask");
    op(1, 1, 1, 12'h00C, 4'hF, 0, 1, "R5 ofs hi clear");
    op(1, 1, 1, 12'h008, 4'hF, 32'd10, 1, "R5 ofs lo");
    // R4 / R6 enable sets the deadline
    begin
      logic [63:0] c0;
      c0 = cnt;
      op(1, 1, 1, 12'h000, 4'hF, 32'h1, 1, "R4 enable");
      rd_lit(1, 12'h010, c0[31:0] + 32'd10, "R6 cmp lo");
      rd_lit(1, 12'h014, c0[63:32], "R6 cmp hi");
    end
    // R7 first expiry
    for (int i = 0; i < 12; i++) op(0, 0, 0, 0, 0, 0, 1, "R7 wait");
    rd_lit(1, 12'h000, 32'h3, "R7 ctrl flags");
    // R9 compare write keeps flags
    op(1, 1, 1, 12'h014, 4'hF, 32'h0000_0001, 1, "R9 cmp hi write");
    rd_lit(1, 12'h000, 32'h3, "R9 flags kept");
    op(1, 1, 1, 12'h014, 4'hF, 0, 1, "R9 cmp hi back");
    op(1, 1, 1, 12'h010, 4'hF, 0, 1, "R9 cmp lo zero");
    // R8 second expiry
    op(0, 0, 0, 0, 0, 0, 1, "R8 expire");
    rd_lit(1, 12'h000, 32'h7, "R8 ctrl flags");
    chk("R8 rst_req high", {63'd0, wdog_rst_req}, 1);
    // R5 refresh write clears both stages
    op(1, 1, 0, 12'h000, 4'hF, 32'hDEAD, 1, "R5 refresh");
    chk("R5 irq cleared", {63'd0, wdog_irq}, 0);
    // R6 disabled: past-due compare yields no expiry
    op(1, 1, 1, 12'h000, 4'hF, 0, 1, "R6 disable");
    op(1, 1, 1, 12'h010, 4'hF, 0, 1, "R6 cmp zero");
    for (int i = 0; i < 5; i++) op(0, 0, 0, 0, 0, 0, 1, "R6 idle");
    rd_lit(1, 12'h000, 0, "R6 no expiry");
    // R7 wrap near the top of the count range
    cnt = 64'hFFFF_FFFF_FFFF_FFFA;
    op(1, 1, 1, 12'h000, 4'hF, 1, 1, "R7 wrap enable");
    for (int i = 0; i < 20; i++) op(0, 0, 0, 0, 0, 0, 1, "R7 wrap run");
    // random mix
    cnt = 64'd5000;
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] k;
      logic [11:0] ra;
      logic [63:0] stp;
      k = 4'($urandom % 16);
      stp = 64'($urandom % 4);
      ra = 12'(($urandom % 7) * 4);
      case (k)
        0:  op(1, 1, 0, 12'h000, 4'hF, $urandom, stp, "R5 rnd refresh");
        1:  op(1, 1, 1, 12'h000, 4'hF, $urandom, stp, "R4 rnd ctrl");
        2:  op(1, 1, 1, 12'h008, 4'hF, $urandom % 16, stp, "R5 rnd ofs lo");
        3:  op(1, 1, 1, 12'h010, 4'hF, 32'(cnt) + ($urandom % 8), stp, "R9 rnd cmp lo");
        4:  op(1, 1, 1, 12'h008, 4'($urandom % 15), $urandom, stp, "R10 rnd partial");
        5:  op(1, 1, 1, 12'h100, 4'hF, $urandom, stp, "R10 rnd unmapped");
        6, 7: op(1, 0, 1, ra, 4'hF, 0, stp, "R6 rnd read");
        8:  op(1, 0, 0, ($urandom % 2) ? 12'hFCC : 12'h000, 4'hF, 0, stp, "R3 rnd rfr read");
        default: op(0, 0, 0, 0, 0, 0, stp, "R7 rnd idle");
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule